// File: doc/BRIEF.md
# Multi-Burst Transfer CRC Checker

This block sits on the device side of a burst-mode parallel disk interface. It follows the data integrity of one command that may be split into several bursts. While a burst is open, every data word the device sends goes through a 16-bit CRC register. At the close of the burst, the host puts its own CRC result on the data bus. The block captures that word and compares it with the local result.

A mismatch is not reported at once. The block notes the first burst whose CRC failed, using a burst number counted from zero within the command. It keeps that record hidden until the command-end pulse, and then publishes it. A command-start pulse wipes both the published report and the pending record, ready for the next command.

The acknowledge input is the active-low level of the host's DMA acknowledge line. A burst is open while this line is asserted (low). The line is treated as asynchronous and passes through a two-flop synchronizer before its edges are used.

Top module: `burst_crc_checker`

## Requirements
- R1: After reset, reportValid, errFlag and errBurst are all zero.
- R2: The CRC register is loaded with 16'h4A50 when a burst opens (the acknowledge line falls). Each accepted word then updates it in one cycle with the polynomial x^16 + x^12 + x^5 + 1 (16'h1021), taking the word's bits most significant first into a left-shifting register with no final inversion.
- R3: When a burst closes (the acknowledge line rises), the hostCrc input is captured within three clock edges and compared with the local CRC. A matching word records no error. The host holds hostCrc steady for at least four cycles after the rise.
- R4: If the CRC of burst k of a command mismatches, and no earlier burst of that command failed, the record becomes error with index k. Bursts are numbered 0, 1, 2 and so on from the command start.
- R5: If several bursts of one command mismatch, the record keeps the index of the first failing burst. Later mismatches do not change it.
- R6: Before the command-end pulse, reportValid and errFlag read 0 and errBurst reads 0, whatever mismatches have happened.
- R7: On a command-end pulse, reportValid becomes 1 and errFlag/errBurst show the record. These values hold until the next command-start pulse.
- R8: A command-start pulse clears reportValid, errFlag and errBurst to 0. It also clears the pending record and restarts burst numbering at 0.

Design parameters include the burst-index width, which defaults to 4 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cmdStart | input | 1 | One-cycle pulse at the start of a command |
| cmdEnd | input | 1 | One-cycle pulse at the end of a command |
| ackN | input | 1 | Active-low DMA acknowledge level, asynchronous |
| wordValid | input | 1 | Data word on wordData is sent this cycle |
| wordData | input | 16 | Data word sent by the device |
| hostCrc | input | 16 | CRC word driven by the host at burst close |
| reportValid | output | 1 | Command report is published |
| errFlag | output | 1 | A CRC mismatch occurred in the command |
| errBurst | output | BURST_W | Index of the first failing burst |

## Verification
The assertions assume that cmdStart, cmdEnd and a burst-close comparison never fall in the same cycle. They also assume that data words are sent only after the synchronized acknowledge has settled low, so seeding, word updates and checks never overlap. The stimulus keeps to these rules in three ways. It waits several cycles after each acknowledge edge before sending words or ending the command. It holds hostCrc for six cycles across the close. It separates each command pulse from burst activity by idle cycles. The sweep covers every pattern of failing bursts in a four-burst command, with burst lengths that vary, so the first-failure index takes every value.

// File: rtl/crc_chk_pkg.sv
package crc_chk_pkg;

  localparam int CRC_W = 16;

  typedef struct packed {
    logic clear;    // command start
    logic seed;     // burst opened
    logic step;     // accept a data word
    logic check;    // burst closed, compare host word
    logic publish;  // command end
  } strobes_t;

  // One-cycle parallel CRC update over a full word, MSB first
  function automatic logic [CRC_W-1:0] crcNext(
      input logic [CRC_W-1:0] cur,
      input logic [CRC_W-1:0] data,
      input logic [CRC_W-1:0] poly);
    logic [CRC_W-1:0] acc;
    logic fb;
    acc = cur;
    for (int i = CRC_W - 1; i >= 0; i--) begin
      fb  = acc[CRC_W-1] ^ data[i];
      acc = {acc[CRC_W-2:0], 1'b0} ^ (fb ? poly : '0);
    end
    return acc;
  endfunction

endpackage

// File: rtl/burst_ctrl.sv
module burst_ctrl
  import crc_chk_pkg::*;
#(
  parameter int BURST_W = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cmdStart,
  input  logic               cmdEnd,
  input  logic               ackN,
  input  logic               wordValid,
  output strobes_t           strb,
  output logic [BURST_W-1:0] burstIdx
);

  logic ackMeta;
  logic ackSync;
  logic ackPrev;
  logic burstOpen;
  logic burstClose;
  logic [BURST_W-1:0] burstCnt;

  // two-flop synchronizer plus history flop; idle level is negated (high)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ackMeta <= 1'b1;
      ackSync <= 1'b1;
      ackPrev <= 1'b1;
    end else begin
      ackMeta <= ackN;
      ackSync <= ackMeta;
      ackPrev <= ackSync;
    end
  end

  assign burstOpen  = ackPrev & ~ackSync;
  assign burstClose = ackSync & ~ackPrev;

  always_comb begin
    strb         = '0;
    strb.clear   = cmdStart;
    strb.publish = cmdEnd;
    strb.seed    = burstOpen;
    strb.check   = burstClose;
    strb.step    = wordValid & ~ackSync & ~ackPrev;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      burstCnt <= '0;
    end else if (cmdStart) begin
      burstCnt <= '0;
    end else if (burstClose) begin
      burstCnt <= burstCnt + 1'b1;
    end
  end

  assign burstIdx = burstCnt;

  // R2/R3: seed, word update and compare are mutually exclusive
  a_r3_phase_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.seed, strb.step, strb.check}));

  // R4: burst numbering advances only on a close
  a_r4_index_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!cmdStart && !strb.check) |=> $stable(burstIdx));

  // R8: command start restarts numbering
  a_r8_index_restart: assert property (@(posedge clk) disable iff (!rstN)
    cmdStart |=> burstIdx == '0);

endmodule

// File: rtl/crc_datapath.sv
module crc_datapath
  import crc_chk_pkg::*;
#(
  parameter int               BURST_W  = 4,
  parameter logic [CRC_W-1:0] CRC_SEED = 16'h4A50,
  parameter logic [CRC_W-1:0] CRC_POLY = 16'h1021
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobes_t           strb,
  input  logic [BURST_W-1:0] burstIdx,
  input  logic [CRC_W-1:0]   wordData,
  input  logic [CRC_W-1:0]   hostCrc,
  output logic               reportValid,
  output logic               errFlag,
  output logic [BURST_W-1:0] errBurst
);

  logic [CRC_W-1:0]   crcReg;
  logic               stickyErr;
  logic [BURST_W-1:0] stickyIdx;
  logic               mismatch;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      crcReg <= CRC_SEED;
    end else if (strb.seed) begin
      crcReg <= CRC_SEED;
    end else if (strb.step) begin
      crcReg <= crcNext(crcReg, wordData, CRC_POLY);
    end
  end

  assign mismatch = strb.check && (hostCrc != crcReg);

  // pending first-failure record
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stickyErr <= 1'b0;
      stickyIdx <= '0;
    end else if (strb.clear) begin
      stickyErr <= 1'b0;
      stickyIdx <= '0;
    end else if (mismatch && !stickyErr) begin
      stickyErr <= 1'b1;
      stickyIdx <= burstIdx;
    end
  end

  // published report
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reportValid <= 1'b0;
      errFlag     <= 1'b0;
      errBurst    <= '0;
    end else if (strb.clear) begin
      reportValid <= 1'b0;
      errFlag     <= 1'b0;
      errBurst    <= '0;
    end else if (strb.publish) begin
      reportValid <= 1'b1;
      errFlag     <= stickyErr;
      errBurst    <= stickyIdx;
    end
  end

  // R2: opening a burst leaves the register at the seed
  a_r2_seeded: assert property (@(posedge clk) disable iff (!rstN)
    strb.seed |=> crcReg == CRC_SEED);

  // R5: the first failure is kept until the next command
  a_r5_first_kept: assert property (@(posedge clk) disable iff (!rstN)
    (stickyErr && !strb.clear) |=> (stickyErr && $stable(stickyIdx)));

  // R6: nothing is shown before the report is published
  a_r6_hidden: assert property (@(posedge clk) disable iff (!rstN)
    !reportValid |-> (!errFlag && errBurst == '0));

  // R7: a published report stays until a command start
  a_r7_report_hold: assert property (@(posedge clk) disable iff (!rstN)
    (reportValid && !strb.clear) |=>
      (reportValid && $stable(errFlag) && $stable(errBurst)));

endmodule

// File: rtl/burst_crc_checker.sv
module burst_crc_checker
  import crc_chk_pkg::*;
#(
  parameter int               BURST_W  = 4,
  parameter logic [CRC_W-1:0] CRC_SEED = 16'h4A50,
  parameter logic [CRC_W-1:0] CRC_POLY = 16'h1021
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cmdStart,
  input  logic               cmdEnd,
  input  logic               ackN,
  input  logic               wordValid,
  input  logic [15:0]        wordData,
  input  logic [15:0]        hostCrc,
  output logic               reportValid,
  output logic               errFlag,
  output logic [BURST_W-1:0] errBurst
);

  strobes_t           strb;
  logic [BURST_W-1:0] burstIdx;

  burst_ctrl #(.BURST_W(BURST_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cmdStart  (cmdStart),
    .cmdEnd    (cmdEnd),
    .ackN      (ackN),
    .wordValid (wordValid),
    .strb      (strb),
    .burstIdx  (burstIdx)
  );

  crc_datapath #(
    .BURST_W  (BURST_W),
    .CRC_SEED (CRC_SEED),
    .CRC_POLY (CRC_POLY)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .burstIdx    (burstIdx),
    .wordData    (wordData),
    .hostCrc     (hostCrc),
    .reportValid (reportValid),
    .errFlag     (errFlag),
    .errBurst    (errBurst)
  );

  // R1: idle after reset
  a_r1_reset_idle: assert property (@(posedge clk)
    $rose(rstN) |-> (!reportValid && !errFlag));

endmodule

// File: tb/burst_crc_checker_tb.sv
module burst_crc_checker_tb;

  localparam int CLK_PERIOD = 10;
  localparam int BW = 4;
  localparam int NB = 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cmdStart = 1'b0;
  logic          cmdEnd = 1'b0;
  logic          ackN = 1'b1;
  logic          wordValid = 1'b0;
  logic [15:0]   wordData = '0;
  logic [15:0]   hostCrc = '0;
  logic          reportValid;
  logic          errFlag;
  logic [BW-1:0] errBurst;

  int  total = 0;
  int  bad = 0;
  bit  finished = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_crc_checker #(.BURST_W(BW)) u_dut (
    .clk(clk), .rstN(rstN), .cmdStart(cmdStart), .cmdEnd(cmdEnd),
    .ackN(ackN), .wordValid(wordValid), .wordData(wordData),
    .hostCrc(hostCrc), .reportValid(reportValid), .errFlag(errFlag),
    .errBurst(errBurst)
  );

  // reference CRC: bitwise long division, MSB first, poly 0x1021
  function automatic logic [15:0] refCrc(input logic [15:0] c, input logic [15:0] w);
    logic [16:0] r;
    r = {1'b0, c};
    for (int b = 15; b >= 0; b--) begin
      r = {r[15:0], 1'b0};
      if (r[16] ^ w[b]) r[15:0] = r[15:0] ^ 16'h1021;
      r[16] = 1'b0;
    end
    return r[15:0];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulseStart();
    @(negedge clk); cmdStart = 1'b1;
    @(negedge clk); cmdStart = 1'b0;
  endtask

  task automatic pulseEnd();
    @(negedge clk); cmdEnd = 1'b1;
    @(negedge clk); cmdEnd = 1'b0;
  endtask

  task automatic runBurst(input int nWords, input bit corrupt);
    logic [15:0] crc;
    crc = 16'h4A50;
    @(negedge clk); ackN = 1'b0;
    idle(5);
    for (int i = 0; i < nWords; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      wordData  = lfsr;
      wordValid = 1'b1;
      crc = refCrc(crc, lfsr);
      @(negedge clk);
    end
    wordValid = 1'b0;
    hostCrc = corrupt ? (crc ^ 16'h0100) : crc;
    @(negedge clk); ackN = 1'b1;
    idle(6);
    hostCrc = 16'hDEAD;
    idle(2);
  endtask

  initial begin
    idle(3);
    check("R1 reportValid", reportValid, 0);
    check("R1 errFlag", errFlag, 0);
    check("R1 errBurst", errBurst, 0);
    rstN = 1'b1;
    idle(2);

    // sweep every failing-burst pattern of a four-burst command
    for (int mask = 0; mask < (1 << NB); mask++) begin
      int expIdx;
      pulseStart();
      check("R8 cleared valid", reportValid, 0);
      check("R8 cleared flag", errFlag, 0);
      check("R8 cleared index", errBurst, 0);
      expIdx = 0;
      for (int b = NB - 1; b >= 0; b--)
        if (mask[b]) expIdx = b;
      for (int b = 0; b < NB; b++)
        runBurst(1 + ((mask + b) % 3), mask[b]);
      check("R6 hidden valid", reportValid, 0);
      check("R6 hidden flag", errFlag, 0);
      pulseEnd();
      idle(1);
      check("R7 published", reportValid, 1);
      if (mask == 0) check("R3 match no error", errFlag, 0);
      else           check("R4 error flag", errFlag, 1);
      if (mask == 0)                 check("R2 index", errBurst, 0);
      else if ((mask & (mask - 1)) != 0) check("R5 first index", errBurst, expIdx);
      else                           check("R4 index", errBurst, expIdx);
      idle(4);
      check("R7 held", {reportValid, errFlag}, {1'b1, mask != 0});
    end

    // R8: numbering restarts; a failure in burst 0 of a new command gives index 0
    pulseStart();
    runBurst(2, 1'b1);
    pulseEnd();
    idle(1);
    check("R8 restart index", {errFlag, errBurst}, {1'b1, 4'd0});

    // R2: single-word burst, host word built from seed directly
    pulseStart();
    runBurst(1, 1'b0);
    runBurst(3, 1'b0);
    pulseEnd();
    idle(1);
    check("R2 clean command", errFlag, 0);

    pulseStart();
    check("R8 final clear", reportValid, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    finished = 1'b1;
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule